// File: doc/BRIEF.md
# Parallel Flash Bulk Erase Sequencer

This block acts as a bus master that wipes an entire parallel flash device on the host's behalf. A single start pulse begins the sequence. The block first waits for the external programming supply to report that it has ramped up. It then writes the erase command byte twice, reads the device until bit 7 of the returned byte is set, and finally reads every address of the array to confirm that each byte holds FFh.

The device-facing side works as a plain asynchronous memory port. It has an active-low chip select, an active-low read strobe and an active-low write strobe, an address bus, and a data bus split into an output, an output enable and an input. Every bus access takes the same shape: a setup phase with chip select low, a strobe phase, and a hold phase. Each phase length is a parameter counted in clock cycles. The host sees a busy flag plus two sticky result flags, one for a completed erase and one for a failed erase.

Top module: `flash_erase_driver`

## Requirements
- R1: After reset, busy_o, done_o, err_o and data_oe_o are low, and ce_no, oe_no and we_no are high.
- R2: A start_i pulse while idle raises busy_o on the next cycle. ce_no stays high in every cycle in which vpp_ready_i has not yet been seen high since that start.
- R3: Once the supply is ready, the block performs exactly two write accesses. Both are at address 0 and both carry data 30h.
- R4: Every access holds ce_no low for SETUP_CYC + PULSE_CYC + HOLD_CYC cycles. The strobe (we_no for a write, oe_no for a read) is low for exactly PULSE_CYC of those cycles, starting after SETUP_CYC cycles.
- R5: data_oe_o is high only during write accesses, and it stays high through the whole of each write. we_no and oe_no are never low together.
- R6: After the second command, the block repeats reads at address 0 until a read returns bit 7 = 1.
- R7: If POLL_LIMIT status reads all return bit 7 = 0, the block ends with err_o = 1 and done_o = 0 and performs no verify reads. A set bit 7 on read number POLL_LIMIT itself counts as success.
- R8: The verify pass reads addresses 0 to 2^ADDR_W-1 in ascending order, one read each. If every byte equals FFh, the block ends with done_o = 1 and err_o = 0.
- R9: The first verify byte that is not FFh ends the run with err_o = 1 and done_o = 0. No further reads follow.
- R10: When busy_o falls, exactly one of done_o or err_o is set. Both flags keep their values with the bus idle (ce_no high) until the next accepted start, which clears them.
- R11: start_i pulses while busy_o is high are ignored. They do not restart the sequence and do not change the number or order of accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Erase request pulse |
| vpp_ready_i | input | 1 | Programming supply at its high level |
| ce_no | output | 1 | Device chip select, active low |
| oe_no | output | 1 | Device read strobe, active low |
| we_no | output | 1 | Device write strobe, active low |
| addr_o | output | ADDR_W | Device address |
| data_o | output | 8 | Write data to device |
| data_oe_o | output | 1 | Enable for the write data driver |
| data_i | input | 8 | Read data from device |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Erase completed and verified (sticky) |
| err_o | output | 1 | Poll timeout or verify mismatch (sticky) |

## Verification
Two pairs of events can land on the same read. The first pair is the poll limit running out on the very read in which bit 7 turns to 1. The second is the verify pass reaching the last address just as that byte proves bad. Directed cases place the status flip at read POLL_LIMIT, which must pass into verify, and one read later, which must time out. They also place a bad byte at the top address and at address 0. The run outcome, the poll read count and the verify read count are each compared with values the bench derives from the case settings. Random cases vary the flip point, the bad byte, the supply delay and stray start pulses around these edges.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] ERASE_CMD  = 8'h30;
  localparam logic [DATA_W-1:0] BLANK_BYTE = 8'hFF;
  localparam int unsigned STATUS_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VPP,
    ST_CMD1,
    ST_CMD2,
    ST_POLL,
    ST_VERIFY
  } ctrl_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } bus_phase_e;
endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_erase_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 2,
  parameter int unsigned HOLD_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ce_no,
  output logic              oe_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] data_i
);
  localparam int unsigned MAX_SP = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned MAX_C  = (MAX_SP > HOLD_CYC) ? MAX_SP : HOLD_CYC;
  localparam int unsigned CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

  bus_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              last_w;

  assign last_w = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (req_i) begin
          phase_q <= PH_SETUP;
          cnt_q   <= SETUP_LD;
          wr_q    <= wr_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
        PH_SETUP: begin
          if (last_w) begin
            phase_q <= PH_STROBE;
            cnt_q   <= PULSE_LD;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_STROBE: begin
          if (last_w) begin
            phase_q <= PH_HOLD;
            cnt_q   <= HOLD_LD;
            if (!wr_q) rdata_q <= data_i; // sample at end of read strobe
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_HOLD: begin
          if (last_w) phase_q <= PH_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign ack_o     = (phase_q == PH_HOLD) && last_w;
  assign rdata_o   = rdata_q;
  assign ce_no     = (phase_q == PH_IDLE);
  assign we_no     = !((phase_q == PH_STROBE) && wr_q);
  assign oe_no     = !((phase_q == PH_STROBE) && !wr_q);
  assign addr_o    = addr_q;
  assign data_o    = wdata_q;
  assign data_oe_o = wr_q && (phase_q != PH_IDLE);
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned POLL_LIMIT = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              vpp_ready_i,
  output logic              req_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned PCNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [PCNT_W-1:0] POLL_LAST = PCNT_W'(POLL_LIMIT - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  ctrl_state_e       state_q;
  logic              issued_q;
  logic [PCNT_W-1:0] poll_cnt_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic              done_q, err_q;
  logic              bus_state_w;

  assign bus_state_w = (state_q == ST_CMD1) || (state_q == ST_CMD2) ||
                       (state_q == ST_POLL) || (state_q == ST_VERIFY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      issued_q   <= 1'b0;
      poll_cnt_q <= '0;
      vaddr_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (req_o) issued_q <= 1'b1;
      else if (ack_i) issued_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (start_i) begin
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          state_q <= ST_VPP;
        end
        ST_VPP: if (vpp_ready_i) state_q <= ST_CMD1;
        ST_CMD1: if (ack_i) state_q <= ST_CMD2;
        ST_CMD2: if (ack_i) begin
          state_q    <= ST_POLL;
          poll_cnt_q <= '0;
        end
        ST_POLL: if (ack_i) begin
          if (rdata_i[STATUS_BIT]) begin
            state_q <= ST_VERIFY;
            vaddr_q <= '0;
          end else if (poll_cnt_q == POLL_LAST) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else poll_cnt_q <= poll_cnt_q + 1'b1;
        end
        ST_VERIFY: if (ack_i) begin
          if (rdata_i != BLANK_BYTE) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (vaddr_q == ADDR_LAST) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else vaddr_q <= vaddr_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o   = bus_state_w && !issued_q;
  assign wr_o    = (state_q == ST_CMD1) || (state_q == ST_CMD2);
  assign addr_o  = (state_q == ST_VERIFY) ? vaddr_q : '0;
  assign wdata_o = ERASE_CMD;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/flash_erase_driver.sv
module flash_erase_driver
  import flash_erase_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned PULSE_CYC  = 2,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned POLL_LIMIT = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              vpp_ready_i,
  output logic              ce_no,
  output logic              oe_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  input  logic [7:0]        data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  logic              req_w, wr_w, ack_w;
  logic [ADDR_W-1:0] req_addr_w;
  logic [DATA_W-1:0] wdata_w, rdata_w;

  flash_erase_ctrl #(
    .ADDR_W    (ADDR_W),
    .POLL_LIMIT(POLL_LIMIT)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .vpp_ready_i(vpp_ready_i),
    .req_o      (req_w),
    .wr_o       (wr_w),
    .addr_o     (req_addr_w),
    .wdata_o    (wdata_w),
    .ack_i      (ack_w),
    .rdata_i    (rdata_w),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  flash_bus_cycle #(
    .ADDR_W   (ADDR_W),
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_w),
    .wr_i     (wr_w),
    .addr_i   (req_addr_w),
    .wdata_i  (wdata_w),
    .ack_o    (ack_w),
    .rdata_o  (rdata_w),
    .ce_no    (ce_no),
    .oe_no    (oe_no),
    .we_no    (we_no),
    .addr_o   (addr_o),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .data_i   (data_i)
  );
endmodule

// File: rtl/flash_erase_checker.sv
module flash_erase_checker
  import flash_erase_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vpp_ready_i,
  input logic       ce_no,
  input logic       oe_no,
  input logic       we_no,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o
);
  logic [15:0] strobe_cnt_q;
  logic        vpp_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_cnt_q <= '0;
      vpp_seen_q   <= 1'b0;
    end else begin
      strobe_cnt_q <= (!we_no || !oe_no) ? strobe_cnt_q + 1'b1 : '0;
      if (!busy_o) vpp_seen_q <= 1'b0;
      else if (vpp_ready_i) vpp_seen_q <= 1'b1;
    end
  end

  assert_vpp_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_no |-> (vpp_seen_q || vpp_ready_i));
  assert_cmd_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (data_o == ERASE_CMD));
  assert_strobe_in_ce_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !oe_no) |-> !ce_no);
  assert_we_setup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |-> $past(!ce_no));
  assert_pulse_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(we_no) || $rose(oe_no)) |-> (strobe_cnt_q == 16'(PULSE_CYC)));
  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !oe_no));
  assert_we_driven_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> data_oe_o);
  assert_read_float_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (oe_no && !ce_no));
  assert_finish_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o ^ err_o));
  assert_idle_bus_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ce_no);
endmodule

bind flash_erase_driver flash_erase_checker #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vpp_ready_i(vpp_ready_i),
  .ce_no      (ce_no),
  .oe_no      (oe_no),
  .we_no      (we_no),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/sim_flash_erase_driver.sv
`timescale 1ns/1ps
module sim_flash_erase_driver;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;
  localparam int SU    = 2;
  localparam int PW    = 3;
  localparam int HD    = 1;
  localparam int LIMIT = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          vpp = 1'b0;
  logic          ce_n, oe_n, we_n, doe, busy, done, err;
  logic [AW-1:0] addr;
  logic [7:0]    dout, din;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [7:0] mem [DEPTH];
  int  pend, pend_init, p_exp;
  bit  mon_clr;
  int  write_cnt, bad_data, read_cnt, addr_err, bus_err, timing_err, early;
  int  burst_len, strobe_len;
  logic prev_ce, prev_we, prev_oe;

  always #2.5 clk = ~clk;

  flash_erase_driver #(
    .ADDR_W(AW), .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD), .POLL_LIMIT(LIMIT)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vpp_ready_i(vpp),
    .ce_no(ce_n), .oe_no(oe_n), .we_no(we_n), .addr_o(addr),
    .data_o(dout), .data_oe_o(doe), .data_i(din),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  // device model: status reads return bit7=0 while erase pending
  assign din = (!ce_n && !oe_n) ? ((write_cnt >= 2 && pend > 0) ? 8'h00 : mem[addr]) : 8'h00;

  function automatic int exp_addr(int idx);
    return (idx < p_exp) ? 0 : idx - p_exp;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (mon_clr) begin
      write_cnt = 0; bad_data = 0; read_cnt = 0; addr_err = 0; bus_err = 0;
      timing_err = 0; early = 0; burst_len = 0; strobe_len = 0; pend = pend_init;
    end else begin
      if (!ce_n && !vpp) early++;
      if (!we_n && !oe_n) bus_err++;
      if (doe && (!oe_n || ce_n)) bus_err++;
      if (!we_n && !doe) bus_err++;
      if (!ce_n) begin
        burst_len++;
        if (!we_n || !oe_n) strobe_len++;
        if (!we_n && prev_we) begin
          write_cnt++;
          if (dout != 8'h30 || addr != '0) bad_data++;
          if (burst_len != SU + 1) timing_err++;
        end
        if (!oe_n && prev_oe) begin
          if (int'(addr) != exp_addr(read_cnt)) addr_err++;
          read_cnt++;
          if (burst_len != SU + 1) timing_err++;
        end
      end
      if (oe_n && !prev_oe && write_cnt >= 2 && pend > 0) pend--;
      if (ce_n && !prev_ce) begin
        if (burst_len != SU + PW + HD || strobe_len != PW) timing_err++;
        burst_len = 0; strobe_len = 0;
      end
    end
    prev_ce = ce_n; prev_we = we_n; prev_oe = oe_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int n_busy, input int bad_addr, input int bad_bit,
                          input int vpp_delay, input bit poke);
    bit timeout, done_exp;
    int v_exp, r_tot;
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
    if (bad_addr >= 0) mem[bad_addr] = 8'hFF ^ (8'h1 << bad_bit); // bit7 stays set
    timeout  = (n_busy >= LIMIT);
    p_exp    = timeout ? LIMIT : n_busy + 1;
    v_exp    = timeout ? 0 : ((bad_addr >= 0) ? bad_addr + 1 : DEPTH);
    done_exp = !timeout && (bad_addr < 0);
    r_tot    = p_exp + v_exp;
    pend_init = n_busy;
    vpp = 1'b0;
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    chk(done === 1'b0 && err === 1'b0, "R10 flags cleared by start", {done, err}, 0);
    for (int i = 0; i < vpp_delay; i++) @(negedge clk);
    chk(busy === 1'b1 && ce_n === 1'b1, "R2 waiting for supply", {busy, ce_n}, 3);
    vpp = 1'b1;
    if (poke) begin
      for (int i = 0; i < 9; i++) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    chk(busy === 1'b0, "R10 sequence ends", busy, 0);
    chk(early == 0, "R2 no access before supply ready", early, 0);
    chk(write_cnt == 2 && bad_data == 0, "R3 two 30h writes at addr 0", write_cnt, 2);
    chk(timing_err == 0, "R4 access phase widths", timing_err, 0);
    chk(bus_err == 0, "R5 data driver and strobes", bus_err, 0);
    chk(read_cnt == r_tot, timeout ? "R7 poll timeout read count" :
        (bad_addr >= 0 ? "R9 stop at first bad byte" : "R6 R8 read count"), read_cnt, r_tot);
    chk(addr_err == 0, "R8 read address order", addr_err, 0);
    chk(done === done_exp && err === !done_exp,
        timeout ? "R7 timeout flags" : (bad_addr >= 0 ? "R9 mismatch flags" : "R8 done flags"),
        {done, err}, {done_exp, !done_exp});
    if (poke) chk(write_cnt == 2 && read_cnt == r_tot, "R11 start while busy ignored", read_cnt, r_tot);
    for (int i = 0; i < 10; i++) @(negedge clk);
    chk(done === done_exp && err === !done_exp && ce_n === 1'b1 && busy === 1'b0,
        "R10 flags held while idle", {done, err}, {done_exp, !done_exp});
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    pend_init = 0; p_exp = 0; mon_clr = 1'b1;
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && err === 0 && doe === 0, "R1 reset flags",
        {busy, done, err, doe}, 0);
    chk(ce_n === 1 && oe_n === 1 && we_n === 1, "R1 reset strobes", {ce_n, oe_n, we_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    run_case(0, -1, 0, 0, 0);
    run_case(3, -1, 0, 6, 1);
    run_case(LIMIT - 1, -1, 0, 1, 0);   // bit7 on last permitted read
    run_case(LIMIT, -1, 0, 2, 0);       // one read too late
    run_case(2, DEPTH - 1, 0, 0, 0);    // bad at top address
    run_case(1, 0, 6, 3, 1);            // bad at first address
    for (int k = 0; k < 8; k++) begin
      int nb, ba;
      nb = $urandom_range(0, LIMIT + 4);
      ba = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, DEPTH - 1)) : -1;
      run_case(nb, ba, $urandom_range(0, 6), $urandom_range(0, 10), 1'($urandom_range(0, 1)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule